// File: doc/BRIEF.md
# Edge-Selectable Dual Capture Unit

This unit timestamps activity on an external event pin. The pin is passed through a two-flop synchroniser and watched for the edges chosen by a 2-bit edge mode. When the chosen edge arrives, the value of a free-running counter, supplied from outside, is stored in one of two capture registers. A one-bit select decides whether the first qualifying edge is stored in capture register 1, or whether the unit counts past one edge and stores the second in capture register 2. The event pin is shared with an output function, so capture works only while the pin-direction input marks it as an input.

Every capture sets a sticky status flag at bit 2 of a small status word. Software clears the flag by writing a 1 to that bit. The clear also re-arms the edge sequence. The flag drives an interrupt line and a wake-up line, and each line has its own enable at bit 2 of its own enable word. A small state machine orders the sequence. In ARM_FIRST it waits for a qualifying edge. In ARM_SECOND it has seen one edge in second-select mode and waits for the next. In HELD a capture has been made and edges are ignored.

The transitions are:
- ARM_FIRST to HELD on an edge with first-select.
- ARM_FIRST to ARM_SECOND on an edge with second-select.
- ARM_SECOND to HELD on an edge.
- ARM_FIRST or ARM_SECOND back to ARM_FIRST on a change of edge mode or select.
- Any state to ARM_FIRST on a clear.

Top module: `dual_capture_unit`

## Requirements
- R1: After reset both capture registers read zero, the status word reads zero, and the interrupt and wake-up outputs are low.
- R2: The edge mode decodes as 0 = no capture, 1 = rising edges only, 2 = falling edges only, 3 = both edges.
- R3: With the select at 0, the first qualifying edge stores the counter value into capture register 1. The value stored is the counter input sampled at the third rising clock edge after the pin changes, and capture register 2 is left unchanged.
- R4: With the select at 1, the first qualifying edge is only counted. The second qualifying edge stores the counter into capture register 2 with the same latency as R3, and capture register 1 is left unchanged.
- R5: While the pin-direction input is 0, no edge causes a capture and the status flag is not set.
- R6: A capture sets status bit 2, which stays set until a status write with bit 2 at 1. A write with bit 2 at 0 leaves it set, and status bits 1 and 0 always read 0.
- R7: While the flag is set, further edges change neither capture register. After a clear, the next qualifying edge captures again.
- R8: While armed, a change of the edge mode or of the select restarts the edge count, so an edge seen before the change does not count toward the second capture.
- R9: The interrupt output equals the flag gated by bit 2 of the interrupt-enable word, and the wake-up output equals the flag gated by bit 2 of the wake-enable word. Bits 1 and 0 of both enable words have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pin | input | 1 | Asynchronous event input |
| cnt_val | input | 32 | Free-running counter value to be captured |
| edge_mode | input | 2 | Edge selection (0 none, 1 rise, 2 fall, 3 both) |
| second_sel | input | 1 | 0 = first edge to register 1, 1 = second edge to register 2 |
| pin_is_input | input | 1 | 1 when the shared pin is an input; capture allowed |
| stat_we | input | 1 | Status write strobe |
| stat_wdata | input | 3 | Status write data; a 1 in bit 2 clears the flag |
| int_en | input | 3 | Interrupt enable word, bit 2 used |
| wake_en | input | 3 | Wake-up enable word, bit 2 used |
| cap1 | output | 32 | Capture register 1 (read-only) |
| cap2 | output | 32 | Capture register 2 (read-only) |
| stat | output | 3 | Status word, flag at bit 2 |
| irq | output | 1 | Capture interrupt |
| wake | output | 1 | Capture wake-up request |

## Verification
A pin change made between clock edges reaches the first synchroniser flop at the next rising edge and the second flop one edge later. The capture register and the flag are loaded at the third rising edge, so they are visible just after it. The interrupt and wake-up lines follow the flag in the same cycle. A status write takes effect at the first rising edge after it is applied. The bench drives the counter from its own cycle count and records the count at each pin change. It expects that count plus two in the capture register, and it reads the outputs at a falling edge at least three edges after the stimulus.

// File: rtl/dcap_pkg.sv
package dcap_pkg;
    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_e;

    typedef enum logic [1:0] {
        ARM_FIRST  = 2'd0,
        ARM_SECOND = 2'd1,
        HELD       = 2'd2
    } seq_state_e;

    localparam int STAT_W   = 3;
    localparam int FLAG_BIT = 2;
endpackage

// File: rtl/dcap_sync.sv
module dcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES < 2) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dcap_edge.sv
module dcap_edge
    import dcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       allow,
    input  logic [1:0] mode,
    output logic       hit
);
    logic prev_q;
    logic rise, fall, picked;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;

    always_comb begin
        unique case (edge_sel_e'(mode))
            EDGE_NONE: picked = 1'b0;
            EDGE_RISE: picked = rise;
            EDGE_FALL: picked = fall;
            EDGE_BOTH: picked = rise | fall;
            default:   picked = 1'b0;
        endcase
    end

    assign hit = allow & picked;
endmodule

// File: rtl/dcap_seq.sv
module dcap_seq
    import dcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic [1:0] edge_mode,
    input  logic       second_sel,
    input  logic       clr_req,
    output logic       cap1_stb,
    output logic       cap2_stb
);
    seq_state_e state_q, state_d;
    logic [2:0] cfg_q;
    logic       cfg_chg;
    logic       rearm;

    assign cfg_chg = (cfg_q != {edge_mode, second_sel});
    assign rearm   = clr_req | (cfg_chg & (state_q != HELD));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= {edge_mode, second_sel};
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARM_FIRST;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (rearm) begin
            state_d = ARM_FIRST;
        end else begin
            unique case (state_q)
                ARM_FIRST:  if (hit) state_d = second_sel ? ARM_SECOND : HELD;
                ARM_SECOND: if (hit) state_d = HELD;
                HELD:       state_d = HELD;
                default:    state_d = ARM_FIRST;
            endcase
        end
    end

    // outputs
    always_comb begin
        cap1_stb = 1'b0;
        cap2_stb = 1'b0;
        if (!rearm) begin
            unique case (state_q)
                ARM_FIRST:  cap1_stb = hit & ~second_sel;
                ARM_SECOND: cap2_stb = hit;
                HELD:       ;
                default:    ;
            endcase
        end
    end

    // R4: a single edge never fills both slots
    p_one_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap1_stb, cap2_stb}));
endmodule

// File: rtl/dual_capture_unit.sv
module dual_capture_unit
    import dcap_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_pin,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic [1:0]        edge_mode,
    input  logic              second_sel,
    input  logic              pin_is_input,
    input  logic              stat_we,
    input  logic [STAT_W-1:0] stat_wdata,
    input  logic [STAT_W-1:0] int_en,
    input  logic [STAT_W-1:0] wake_en,
    output logic [CNT_W-1:0]  cap1,
    output logic [CNT_W-1:0]  cap2,
    output logic [STAT_W-1:0] stat,
    output logic              irq,
    output logic              wake
);
    logic             evt_sync;
    logic             hit;
    logic             cap1_stb, cap2_stb;
    logic             clr_req;
    logic             flag_q;
    logic [CNT_W-1:0] cap1_q, cap2_q;

    assign clr_req = stat_we & stat_wdata[FLAG_BIT];

    dcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(evt_pin), .q(evt_sync)
    );

    dcap_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(evt_sync),
        .allow(pin_is_input), .mode(edge_mode), .hit(hit)
    );

    dcap_seq u_seq (
        .clk(clk), .rst_n(rst_n), .hit(hit), .edge_mode(edge_mode),
        .second_sel(second_sel), .clr_req(clr_req),
        .cap1_stb(cap1_stb), .cap2_stb(cap2_stb)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap1_q <= '0;
            cap2_q <= '0;
        end else begin
            if (cap1_stb) cap1_q <= cnt_val;
            if (cap2_stb) cap2_q <= cnt_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      flag_q <= 1'b0;
        else if (cap1_stb || cap2_stb)   flag_q <= 1'b1;
        else if (clr_req)                flag_q <= 1'b0;
    end

    always_comb begin
        stat           = '0;
        stat[FLAG_BIT] = flag_q;
    end

    assign cap1 = cap1_q;
    assign cap2 = cap2_q;
    assign irq  = flag_q & int_en[FLAG_BIT];
    assign wake = flag_q & wake_en[FLAG_BIT];

    p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(cap1_stb || cap2_stb));

    p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> !flag_q);

    p_held_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_req) |-> !(cap1_stb || cap2_stb));

    p_no_input_no_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_is_input |=> ($stable(cap1_q) && $stable(cap2_q) && !$rose(flag_q)));

    p_cap1_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cap1_q) |-> $past(cap1_stb));
endmodule

// File: tb/tb_dual_capture_unit.sv
module tb_dual_capture_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_pin = 1'b0;
    logic [31:0] cnt_val = 32'h1000_0000;
    logic [1:0]  edge_mode = 2'd0;
    logic        second_sel = 1'b0;
    logic        pin_is_input = 1'b0;
    logic        stat_we = 1'b0;
    logic [2:0]  stat_wdata = 3'b000;
    logic [2:0]  int_en = 3'b100;
    logic [2:0]  wake_en = 3'b100;
    logic [31:0] cap1, cap2;
    logic [2:0]  stat;
    logic        irq, wake;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [31:0] exp_c1 = 32'h0;
    logic [31:0] exp_c2 = 32'h0;
    logic        exp_flag = 1'b0;

    // row: [7:6] mode, [5] select, [4] pin is input, [3] start level, [2:0] toggles
    localparam logic [7:0] VEC [8] = '{
        8'b01_0_1_0_010, 8'b10_0_1_0_010, 8'b11_1_1_0_011, 8'b01_1_1_0_100,
        8'b00_0_1_0_011, 8'b11_0_0_0_011, 8'b10_1_1_1_011, 8'b11_0_1_1_010
    };

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) cnt_val <= cnt_val + 32'd1;

    dual_capture_unit dut (
        .clk(clk), .rst_n(rst_n), .evt_pin(evt_pin), .cnt_val(cnt_val),
        .edge_mode(edge_mode), .second_sel(second_sel), .pin_is_input(pin_is_input),
        .stat_we(stat_we), .stat_wdata(stat_wdata), .int_en(int_en), .wake_en(wake_en),
        .cap1(cap1), .cap2(cap2), .stat(stat), .irq(irq), .wake(wake)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic stat_write(input logic [2:0] d);
        stat_we = 1'b1; stat_wdata = d;
        step(1);
        stat_we = 1'b0; stat_wdata = 3'b000;
        step(1);
    endtask

    task automatic setup(input logic [1:0] m, input logic s, input logic dir, input logic lvl);
        edge_mode = 2'd0;
        step(2);
        evt_pin = lvl;
        step(5);
        edge_mode = m; second_sel = s; pin_is_input = dir;
        step(2);
        stat_write(3'b100);
        exp_flag = 1'b0;
    endtask

    task automatic toggle(output logic [31:0] stamp);
        evt_pin = ~evt_pin;
        stamp = cnt_val;
        step(5);
    endtask

    task automatic check_outputs(input string req, input logic wen);
        chk(req, cap1, exp_c1);
        chk(req, cap2, exp_c2);
        chk(req, {29'd0, stat}, {29'd0, exp_flag, 2'b00});
        chk("R9 irq", {31'd0, irq}, {31'd0, exp_flag});
        chk("R9 wake", {31'd0, wake}, {31'd0, exp_flag & wen});
    endtask

    initial begin
        logic [31:0] st;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 cap1", cap1, 32'h0);
        chk("R1 cap2", cap2, 32'h0);
        chk("R1 stat", {29'd0, stat}, 32'h0);
        chk("R1 irq/wake", {30'd0, irq, wake}, 32'h0);

        // table walk: R2 R3 R4 R5 R7 R9
        for (int r = 0; r < 8; r++) begin
            logic [1:0] m;
            logic s, dir, lvl, captured;
            int ntog, cnt;
            m = VEC[r][7:6]; s = VEC[r][5]; dir = VEC[r][4]; lvl = VEC[r][3];
            ntog = int'(VEC[r][2:0]);
            wake_en = r[0] ? 3'b100 : 3'b011;
            setup(m, s, dir, lvl);
            cnt = 0; captured = 1'b0;
            for (int t = 0; t < ntog; t++) begin
                logic nl, q;
                toggle(st);
                nl = evt_pin;
                q = dir && ((m == 2'd3) || (m == 2'd1 && nl) || (m == 2'd2 && !nl));
                if (q && !captured) begin
                    cnt++;
                    if (!s && cnt == 1) begin exp_c1 = st + 32'd2; captured = 1'b1; end
                    if (s && cnt == 2)  begin exp_c2 = st + 32'd2; captured = 1'b1; end
                end
            end
            exp_flag = captured;
            check_outputs(dir ? "R2 R3 R4 R7 row" : "R5 row", r[0]);
        end

        // R6: write-one-to-clear
        wake_en = 3'b100;
        setup(2'd1, 1'b0, 1'b1, 1'b0);
        toggle(st);
        exp_c1 = st + 32'd2; exp_flag = 1'b1;
        check_outputs("R6 set", 1'b1);
        stat_write(3'b011);
        chk("R6 write zero keeps flag", {29'd0, stat}, 32'h4);
        stat_write(3'b100);
        exp_flag = 1'b0;
        chk("R6 write one clears", {29'd0, stat}, 32'h0);

        // R7: re-armed after clear
        toggle(st);
        check_outputs("R7 falling ignored", 1'b1);
        toggle(st);
        exp_c1 = st + 32'd2; exp_flag = 1'b1;
        check_outputs("R7 recapture", 1'b1);

        // R8: mode change restarts the count
        setup(2'd1, 1'b1, 1'b1, 1'b0);
        toggle(st);
        edge_mode = 2'd3;
        step(2);
        toggle(st);
        check_outputs("R8 after change one edge", 1'b1);
        toggle(st);
        exp_c2 = st + 32'd2; exp_flag = 1'b1;
        check_outputs("R8 second edge", 1'b1);

        // R9: enable bit 2 gates irq
        int_en = 3'b011;
        step(1);
        chk("R9 irq masked", {31'd0, irq}, 32'h0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule